// File: doc/BRIEF.md
# Four-Way Pseudo-LRU Victim Selector

This block holds the replacement state of every set of a 4-way set-associative cache and names the way to be replaced when a lookup misses. For each access the cache controller gives a set index, a hit flag and, on a hit, the way that hit. It also gives the per-way valid and dirty bits of the addressed set. The block returns the victim way and says whether that victim must be written back before it is refilled.

A static mode input selects one of two policies, and both share one 4-bit state word per set. In tree mode three bits form a two-level decision tree: a root bit chooses between the lower pair (ways 0/1) and the upper pair (ways 2/3), and one leaf bit per pair chooses within it. In flag mode each way has a recently-used flag. Whatever the mode, a way that is not valid is always taken before any policy is applied.

The victim is decoded combinationally from the state of the set on `acc_set`, so it is ready in the same cycle as a miss. The state update is registered on the clock edge that ends the access.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset every set's state is zero. With all ways valid, a set that has not been accessed yields victim way 0 in both modes.
- R2: If any way of the addressed set is invalid, the victim is the lowest-numbered invalid way, in both modes, whatever the policy state.
- R3: Tree mode, all ways valid. Root bit B1 = 1 means the lower pair (ways 0/1) was used more recently, so the victim comes from ways 2/3. Inside that pair, B2 = 1 means way 2 was used more recently, so the victim is way 3; otherwise it is way 2. B1 = 0 sends the victim to ways 0/1. Inside that pair, B0 = 1 means way 0 was used more recently, so the victim is way 1; otherwise it is way 0.
- R4: Tree mode. On a hit to way w, or on a miss that refills victim w, B1 and the leaf bit of w's pair are set so that both point away from w. The other leaf bit is left unchanged.
- R5: Flag mode. A hit or a refill sets the flag of the way that was touched. With all ways valid, the victim is the lowest-numbered way whose flag is 0.
- R6: Flag mode. If setting a flag would make all four flags 1, the other three flags are cleared and only the flag of the way just touched stays set.
- R7: `wb_needed` is 1 exactly when a miss strobe picks a victim that is both valid and dirty. It is 0 on hits, when no access is strobed, and when the victim is an invalid way.
- R8: An access changes only the state of its own set. Other sets keep their victims.
- R9: The victim for the addressed set appears in the same cycle as the strobe. The update made by an access is seen from the next cycle on, including by a back-to-back access to the same set.
- R10: While `acc_valid` is 0 the state does not change, whatever the hit, way and set inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all replacement state |
| mode_mru | input | 1 | Policy select: 0 tree, 1 recently-used flags; change only while in reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | 1 on a hit, 0 on a miss |
| acc_hit_way | input | 2 | Way that hit (used when acc_hit is 1) |
| way_valid | input | 4 | Valid bit of each way of the addressed set |
| way_dirty | input | 4 | Dirty bit of each way of the addressed set |
| victim_way | output | 2 | Way to replace for the addressed set |
| wb_needed | output | 1 | Chosen victim is valid and dirty on a miss strobe |

## Verification
Two functions can act in the same cycle. In one cycle a miss strobe both picks a victim from the present state and, on the closing edge, writes that victim back into the state as the most recently used way. The bench drives misses to one set in consecutive cycles and samples the victim in the strobe cycle and then again in the next cycle. The first sample must follow the old state and the second the new one. Invalid-first allocation overlaps with the policy update in the same way: a refill of an invalid way must still move the tree bits or flags, and this is judged later through the victim once all ways are valid.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int NWAYS = 4;
  typedef logic [1:0] way_t;
  typedef logic [3:0] rstate_t;

  // tree bits: [0] lower-pair leaf, [1] root, [2] upper-pair leaf
  function automatic way_t tree_pick(input rstate_t st);
    if (st[1]) return st[2] ? 2'd3 : 2'd2;
    else       return st[0] ? 2'd1 : 2'd0;
  endfunction

  function automatic rstate_t tree_touch(input rstate_t st, input way_t w);
    rstate_t n;
    n = st;
    n[3] = 1'b0;
    if (!w[1]) begin
      n[1] = 1'b1;
      n[0] = ~w[0];
    end else begin
      n[1] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic way_t lowest_zero(input logic [3:0] f);
    way_t p;
    p = 2'd0;
    for (int i = NWAYS - 1; i >= 0; i--)
      if (!f[i]) p = 2'(i);
    return p;
  endfunction

  function automatic rstate_t mru_touch(input rstate_t st, input way_t w);
    rstate_t n;
    n = st | (4'b0001 << w);
    if (&n) n = 4'b0001 << w;
    return n;
  endfunction
endpackage

// File: rtl/plru_state_store.sv
module plru_state_store
  import plru_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output rstate_t          rd_state,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  rstate_t          wr_state
);
  rstate_t mem [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem[s] <= '0;
      else if (wr_en && wr_set == SET_W'(s))     mem[s] <= wr_state;
    end
  end

  assign rd_state = mem[rd_set];
endmodule

// File: rtl/plru_policy.sv
module plru_policy
  import plru_pkg::*;
(
  input  logic    mode_mru,
  input  rstate_t cur,
  input  way_t    touch_way,
  output way_t    pick,
  output rstate_t next
);
  way_t    tree_p, mru_p;
  rstate_t tree_n, mru_n;

  always_comb begin
    tree_p = tree_pick(cur);
    tree_n = tree_touch(cur, touch_way);
    mru_p  = lowest_zero(cur);
    mru_n  = mru_touch(cur, touch_way);
  end

  assign pick = mode_mru ? mru_p : tree_p;
  assign next = mode_mru ? mru_n : tree_n;
endmodule

// File: rtl/plru_alloc.sv
module plru_alloc
  import plru_pkg::*;
(
  input  logic [3:0] way_valid,
  input  way_t       pol_pick,
  output way_t       victim,
  output logic       inv_found
);
  assign inv_found = ~&way_valid;
  assign victim    = inv_found ? lowest_zero(way_valid) : pol_pick;
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int SETS  = 16,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_mru,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [1:0]       acc_hit_way,
  input  logic [3:0]       way_valid,
  input  logic [3:0]       way_dirty,
  output logic [1:0]       victim_way,
  output logic             wb_needed
);
  rstate_t st_cur, st_next;
  way_t    pol_pick, victim, touch_way;
  logic    inv_found, miss_evt, upd_evt;

  assign miss_evt  = acc_valid & ~acc_hit;
  assign upd_evt   = acc_valid;
  assign touch_way = acc_hit ? acc_hit_way : victim;

  plru_state_store #(.SETS(SETS), .SET_W(SET_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_set(acc_set), .rd_state(st_cur),
    .wr_en(upd_evt), .wr_set(acc_set), .wr_state(st_next)
  );

  plru_policy u_pol (
    .mode_mru(mode_mru), .cur(st_cur), .touch_way(touch_way),
    .pick(pol_pick), .next(st_next)
  );

  plru_alloc u_alloc (
    .way_valid(way_valid), .pol_pick(pol_pick),
    .victim(victim), .inv_found(inv_found)
  );

  assign victim_way = victim;
  assign wb_needed  = miss_evt & way_valid[victim] & way_dirty[victim];
endmodule

// File: rtl/plru_victim_chk.sv
module plru_victim_chk #(
  parameter int SET_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_mru,
  input logic             acc_valid,
  input logic [SET_W-1:0] acc_set,
  input logic             acc_hit,
  input logic [3:0]       way_valid,
  input logic [3:0]       way_dirty,
  input logic [1:0]       victim_way,
  input logic             wb_needed,
  input logic [3:0]       st_cur
);
  a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (way_valid != 4'hF) |-> !way_valid[victim_way]);

  a_r2_lowest_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (way_valid != 4'hF) |->
      ((way_valid & ((4'b0001 << victim_way) - 4'b0001)) == ((4'b0001 << victim_way) - 4'b0001)));

  a_r3_tree_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_mru && way_valid == 4'hF) |-> (victim_way[1] == st_cur[1]));

  a_r5_mru_victim_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_mru && way_valid == 4'hF) |-> !st_cur[victim_way]);

  a_r6_mru_never_full: assert property (@(posedge clk) disable iff (!rst_n)
    mode_mru |-> !(&st_cur));

  a_r7_wb_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wb_needed |-> (acc_valid && !acc_hit && way_valid[victim_way] && way_dirty[victim_way]));

  a_r7_wb_missing: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && way_valid[victim_way] && way_dirty[victim_way]) |-> wb_needed);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(acc_valid) && $stable(acc_set)) |-> $stable(st_cur));
endmodule

bind plru_victim_sel plru_victim_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_mru(mode_mru), .acc_valid(acc_valid),
  .acc_set(acc_set), .acc_hit(acc_hit), .way_valid(way_valid),
  .way_dirty(way_dirty), .victim_way(victim_way), .wb_needed(wb_needed),
  .st_cur(st_cur)
);

// File: tb/sim_plru_victim_sel.sv
module sim_plru_victim_sel;
  localparam int SETS = 16;
  localparam int SW   = $clog2(SETS);

  logic clk = 1'b0, rst_n = 1'b0, mode_mru = 1'b0;
  logic acc_valid = 1'b0, acc_hit = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic [1:0] acc_hit_way = '0;
  logic [3:0] way_valid = 4'hF, way_dirty = 4'h0;
  logic [1:0] victim_way;
  logic wb_needed;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  plru_victim_sel #(.SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_mru(mode_mru), .acc_valid(acc_valid),
    .acc_set(acc_set), .acc_hit(acc_hit), .acc_hit_way(acc_hit_way),
    .way_valid(way_valid), .way_dirty(way_dirty),
    .victim_way(victim_way), .wb_needed(wb_needed)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0; mode_mru = m; acc_valid = 1'b0;
    way_valid = 4'hF; way_dirty = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one strobed access; victim and wb sampled in the strobe cycle
  task automatic acc(input int s, input logic h, input int w,
                     output int vic, output int wb);
    @(negedge clk);
    acc_valid = 1'b1; acc_set = SW'(s); acc_hit = h; acc_hit_way = 2'(w);
    #2;
    vic = victim_way; wb = wb_needed;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic peek(input int s, output int vic);
    @(negedge clk);
    acc_valid = 1'b0; acc_set = SW'(s);
    #2;
    vic = victim_way;
  endtask

  task automatic t_tree;
    int v, wb;
    do_reset(1'b0);
    peek(3, v);  chk("R1 tree reset victim", v, 0);
    acc(3, 1, 0, v, wb); peek(3, v); chk("R4 tree hit w0", v, 2);
    acc(3, 1, 2, v, wb); peek(3, v); chk("R3 tree hit w2", v, 1);
    acc(3, 1, 1, v, wb); peek(3, v); chk("R3 tree hit w1", v, 3);
    acc(3, 0, 0, v, wb); chk("R9 miss victim same cycle", v, 3);
    acc(3, 0, 0, v, wb); chk("R9 back-to-back sees update", v, 0);
    peek(3, v); chk("R4 refill w0 moves tree", v, 2);
    peek(5, v); chk("R8 other set untouched", v, 0);
    // idle cycle carrying a hit to way 2 must not change set 3
    @(negedge clk);
    acc_valid = 1'b0; acc_set = SW'(3); acc_hit = 1'b1; acc_hit_way = 2'd2;
    @(posedge clk); #1;
    peek(3, v); chk("R10 no strobe no change", v, 2);
  endtask

  task automatic t_mru;
    int v, wb;
    do_reset(1'b1);
    peek(2, v); chk("R1 mru reset victim", v, 0);
    acc(2, 1, 0, v, wb); peek(2, v); chk("R5 mru hit w0", v, 1);
    acc(2, 1, 2, v, wb); peek(2, v); chk("R5 mru hit w2", v, 1);
    acc(2, 0, 0, v, wb); chk("R5 mru miss picks w1", v, 1);
    peek(2, v); chk("R5 mru refill sets w1", v, 3);
    acc(2, 1, 3, v, wb); peek(2, v); chk("R6 mru saturation clears", v, 0);
    acc(2, 1, 0, v, wb); peek(2, v); chk("R6 mru after clear", v, 1);
    peek(9, v); chk("R8 mru other set untouched", v, 0);
  endtask

  task automatic t_invalid;
    int v, wb;
    do_reset(1'b0);
    acc(3, 1, 3, v, wb);            // tree now points at lower pair
    way_valid = 4'b1010;
    peek(3, v); chk("R2 lowest invalid w0", v, 0);
    way_valid = 4'b1011;
    peek(3, v); chk("R2 lowest invalid w2", v, 2);
    way_valid = 4'b1110; way_dirty = 4'hF;
    acc(7, 0, 0, v, wb);
    chk("R2 refill invalid w0", v, 0);
    chk("R7 invalid victim no writeback", wb, 0);
    way_valid = 4'hF; way_dirty = 4'h0;
    peek(7, v); chk("R4 refill of invalid updates tree", v, 2);
    do_reset(1'b1);
    way_valid = 4'b0111;
    peek(4, v); chk("R2 mru invalid w3", v, 3);
    way_valid = 4'hF;
  endtask

  task automatic t_wb;
    int v, wb;
    do_reset(1'b0);
    way_dirty = 4'b0001;
    peek(1, v); chk("R7 idle no writeback", int'(wb_needed), 0);
    acc(1, 1, 0, v, wb); chk("R7 hit no writeback", wb, 0);
    acc(6, 0, 0, v, wb); chk("R7 dirty victim w0", v, 0);
    chk("R7 dirty victim writeback", wb, 1);
    way_dirty = 4'b1110;
    acc(8, 0, 0, v, wb); chk("R7 clean victim no writeback", wb, 0);
    way_dirty = 4'h0;
  endtask

  initial begin
    t_tree();
    t_mru();
    t_invalid();
    t_wb();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule